// File: doc/BRIEF.md
# Predecoded Word-Line and Byte-Strobe Decoder

This block sits in front of a small standard-cell memory array of 256 words. It turns an 8-bit word address into one-hot word selection through a three-stage predecode tree. The tree alternates between active-low and active-high stages. The first stage uses 2-input NANDs on 2-bit address slices. The second stage uses 2-input NORs that combine slice pairs into nibble decodes. The third stage uses 2-input NANDs that cross the two nibble decodes into 256 active-low word lines.

Each word line is combined with the chip enable and the per-byte write enables into a 3-input NOR of active-low terms. This gives four byte write strobes per word, which drive the array's input multiplexers in the same cycle. The inverted word lines are also registered when the chip enable is high. The result is a registered one-hot read select for the array's output multiplexer. A registered copy of the read address is kept next to it, and the two always name the same word.

Top module: `word_predecoder`

## Requirements
- R1: For every address value, exactly one of the 256 internal word lines is active. At the ports this shows as a read select with exactly one bit set after a load.
- R2: Output `wr_stb` bit `w*4+b` is high in the same cycle exactly when `ce` is 1, `we[b]` is 1 and `addr` equals `w`. This is purely combinational.
- R3: While `ce` is 0, every bit of `wr_stb` is 0, whatever `addr` and `we` are.
- R4: While `we` is all zeros, every bit of `wr_stb` is 0.
- R5: At a rising clock edge with `ce` high, `rd_addr` takes `addr`, and `rd_sel` takes a one-hot value whose bit `addr` is set. Both are visible after that edge.
- R6: At a rising clock edge with `ce` low, `rd_addr` and `rd_sel` keep their values.
- R7: A synchronous reset (`rst_n` low at a rising edge) sets `rd_addr` to 0 and `rd_sel` to bit 0 only.
- R8: Out of reset, `rd_sel` always equals a one placed at bit position `rd_addr`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ce | input | 1 | Chip enable, active high |
| addr | input | 8 | Word address |
| we | input | 4 | Per-byte write enables, bit b for byte b |
| wr_stb | output | 1024 | Byte write strobes, bit w*4+b for word w, byte b |
| rd_sel | output | 256 | Registered one-hot read select |
| rd_addr | output | 8 | Registered read address |

## Verification
The write strobes are combinational. The bench drives `addr`, `we` and `ce` just after a falling edge and compares `wr_stb` one nanosecond later, before the next rising edge. The read select and read address take one register stage. The bench compares them one nanosecond after the rising edge that follows the stimulus, against a model address that is updated only when `ce` was high at that edge. The sweep covers all 256 addresses against all 16 enable patterns with `ce` high. A second pass with `ce` low checks that the strobes are silent and that the registered pair does not move.

// File: rtl/word_predecoder.sv
module word_predecoder #(
  parameter int BYTES = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ce,
  input  logic [7:0]              addr,
  input  logic [BYTES-1:0]        we,
  output logic [256*BYTES-1:0]    wr_stb,
  output logic [255:0]            rd_sel,
  output logic [7:0]              rd_addr
);
  localparam int AW    = 8;
  localparam int WORDS = 1 << AW;
  localparam int SLICES = AW / 2;
  localparam int NIB   = 16;

  logic [AW-1:0]        addr_n;
  logic                 ce_n;
  logic [BYTES-1:0]     we_n;
  logic [SLICES*4-1:0]  pre2_n;
  logic [2*NIB-1:0]     pre4;
  logic [WORDS-1:0]     word_n;

  assign addr_n = ~addr;
  assign ce_n   = ~ce;
  assign we_n   = ~we;

  for (genvar s = 0; s < SLICES; s++) begin : g_slice
    for (genvar v = 0; v < 4; v++) begin : g_val
      logic lo, hi;
      assign lo = v[0] ? addr[2*s]   : addr_n[2*s];
      assign hi = v[1] ? addr[2*s+1] : addr_n[2*s+1];
      assign pre2_n[s*4+v] = ~(lo & hi);
    end
  end

  for (genvar h = 0; h < 2; h++) begin : g_half
    for (genvar v = 0; v < NIB; v++) begin : g_val
      assign pre4[h*NIB+v] = ~(pre2_n[(2*h)*4 + (v % 4)] | pre2_n[(2*h+1)*4 + (v / 4)]);
    end
  end

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    assign word_n[w] = ~(pre4[w % NIB] & pre4[NIB + (w / NIB)]);
    for (genvar b = 0; b < BYTES; b++) begin : g_byte
      assign wr_stb[w*BYTES+b] = ~(word_n[w] | ce_n | we_n[b]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_addr <= '0;
      rd_sel  <= {{(WORDS-1){1'b0}}, 1'b1};
    end else if (ce) begin
      rd_addr <= addr;
      rd_sel  <= ~word_n;
    end
  end

  // R1
  word_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~word_n) == 1);

  // R1
  nibble_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(pre4) == 2);

  // R3
  ce_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ce |-> (wr_stb == '0));

  // R4
  we_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we == '0) |-> (wr_stb == '0));

  // R2
  stb_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ce |-> ($countones(wr_stb) == $countones(we)));

  // R5
  load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ce |=> (rd_addr == $past(addr)));

  // R6
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ce |=> ($stable(rd_addr) && $stable(rd_sel)));

  // R8
  sel_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_sel == (256'(1) << rd_addr));
endmodule

// File: tb/tb_word_predecoder.sv
`timescale 1ns/1ps
module tb_word_predecoder;
  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ce = 1'b0;
  logic [7:0]    addr = '0;
  logic [3:0]    we = '0;
  logic [1023:0] wr_stb;
  logic [255:0]  rd_sel;
  logic [7:0]    rd_addr;

  int compared = 0;
  int mismatched = 0;
  logic [7:0] exp_addr;

  word_predecoder #(.BYTES(4)) dut (
    .clk(clk), .rst_n(rst_n), .ce(ce), .addr(addr), .we(we),
    .wr_stb(wr_stb), .rd_sel(rd_sel), .rd_addr(rd_addr)
  );

  always #2.5 clk = ~clk;

  function automatic logic [1023:0] exp_stb(input logic c, input logic [7:0] a, input logic [3:0] e);
    logic [1023:0] r;
    r = '0;
    if (c)
      for (int b = 0; b < 4; b++)
        if (e[b]) r[int'(a)*4+b] = 1'b1;
    return r;
  endfunction

  task automatic check_stb(input string req);
    logic [1023:0] x;
    x = exp_stb(ce, addr, we);
    compared++;
    if (wr_stb !== x) begin
      mismatched++;
      $display("FAIL %s stb addr=%0d we=%b ce=%b: got ones=%0d exp ones=%0d",
               req, addr, we, ce, $countones(wr_stb), $countones(x));
    end
  endtask

  task automatic check_rd(input string req);
    logic [255:0] xs;
    xs = 256'(1) << exp_addr;
    compared++;
    if (rd_addr !== exp_addr || rd_sel !== xs) begin
      mismatched++;
      $display("FAIL %s rd_addr=%0d exp=%0d sel_ones=%0d sel_ok=%b",
               req, rd_addr, exp_addr, $countones(rd_sel), rd_sel === xs);
    end
  endtask

  task automatic step(input logic c, input logic [7:0] a, input logic [3:0] e, input string req);
    @(negedge clk);
    ce = c; addr = a; we = e;
    #1;
    check_stb(req);
    @(posedge clk);
    if (c) exp_addr = a;
    #1;
    check_rd(req);
  endtask

  initial begin
    #200000;
    mismatched++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    addr = 8'd77; ce = 1'b1;
    repeat (3) @(posedge clk);
    exp_addr = 8'd0;
    #1;
    check_rd("R7");
    @(negedge clk);
    rst_n = 1'b1;
    ce = 1'b0;
    // R2 R5 R1 R8: full sweep with chip enable high
    for (int a = 0; a < 256; a++)
      for (int e = 0; e < 16; e++)
        step(1'b1, 8'(a), 4'(e), (e == 0) ? "R4" : "R2_R5");
    // R3 R6: chip enable low, strobes silent and registered pair held
    for (int a = 0; a < 256; a += 3)
      step(1'b0, 8'(a), 4'hF, "R3_R6");
    step(1'b1, 8'd200, 4'h5, "R5");
    step(1'b0, 8'd13,  4'hA, "R6");
    step(1'b1, 8'd255, 4'h8, "R1");
    step(1'b1, 8'd0,   4'h1, "R8");
    @(negedge clk);
    rst_n = 1'b0; ce = 1'b1; addr = 8'd99;
    @(posedge clk);
    exp_addr = 8'd0;
    #1;
    check_rd("R7");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule